// File: doc/BRIEF.md
# Serial Addressed Multichannel DAC Code Register

This block is the digital front end of a ten-channel digital-to-analog converter. A host sends 14-bit frames one bit at a time on a serial data line. Each rising edge of the shift clock captures one bit. Each frame carries a 4-bit channel number in its upper bits and a 10-bit conversion code in its lower bits.

When the load strobe is high, the frame's channel number picks one of ten code registers, and the code is written into that register only. The ten registers drive ten parallel 10-bit outputs, which are meant to feed resistor-ladder converters. The ideal level for code N is the low reference plus N/1024 of the span between the references.

A bit-order input chooses how the data field maps onto the code. The bit leaving the top of the shift register appears on a cascade output, so several devices can share one serial line. An active-low reset clears everything.

Top module: `sdac_front`

## Requirements
- R1: While the load input is low, each rising clock edge shifts the register one place toward its top bit, and the serial input enters bit 0.
- R2: The cascade output is bit 13 of the shift register. A bit sent on the serial input therefore reappears on the cascade output after 14 shifting edges. The first bit of a frame is its bit 13.
- R3: In a frame, bits 13..10 are the channel number and bits 9..0 are the data field.
- R4: A clock edge with load high and channel number k in 1..10 writes the mapped data field into channel k. Channel k's code is bits (k-1)*10+9 .. (k-1)*10 of the codes output. All other channels keep their codes.
- R5: A load whose channel number is 0, 11, 12, 13, 14 or the test code 15 writes no channel.
- R6: If the bit-order input is high at the load edge, code bit i takes data-field bit 9-i. If it is low, code bit i takes data-field bit i. The bit-order input has no effect while bits are being shifted.
- R7: While reset is low, every channel code is zero and the shift register is cleared, so the cascade output is 0.
- R8: While load stays high, the shift register holds its contents. Each further edge rewrites the same value, with no other side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Serial frame data |
| ld | input | 1 | Load strobe, active high |
| rev | input | 1 | Data-field bit-order select |
| dout | output | 1 | Cascade output (register top bit) |
| codes | output | 100 | Ten 10-bit channel codes, channel 1 in the lowest bits |

## Verification
The bench builds the block with its default parameters: ten channels, a 10-bit code and a 4-bit channel number. With these values all sixteen channel numbers can be reached, including the unused ones and the test code. Every channel receives a walking one, all-zeros, all-ones and one mixed code under both bit orders. The bit-order input is held at the opposite value during shifting, which shows that only its value at the load edge counts. A load held for several cycles with the serial line toggling shows that the register does not shift during a load.

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int NCH = 10,
  parameter int DW  = 10,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              ld,
  input  logic              rev,
  output logic              dout,
  output logic [NCH*DW-1:0] codes
);
  localparam int FW = AW + DW;

  logic [FW-1:0] sr;
  logic [AW-1:0] chan;
  logic [DW-1:0] word;

  assign chan = sr[FW-1:DW];
  assign dout = sr[FW-1];

  always_comb
    for (int i = 0; i < DW; i++)
      word[i] = rev ? sr[DW-1-i] : sr[i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   sr <= '0;
    else if (!ld) sr <= {sr[FW-2:0], din};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                         q <= '0;
      else if (ld && chan == AW'(c + 1))  q <= word;
    assign codes[c*DW +: DW] = q;
  end
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int NCH = 10,
  parameter int DW  = 10,
  parameter int AW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              din,
  input logic              ld,
  input logic              rev,
  input logic [AW+DW-1:0]  sr,
  input logic              dout,
  input logic [NCH*DW-1:0] codes
);
  localparam int FW = AW + DW;

  function automatic logic [DW-1:0] remap(input logic [DW-1:0] d, input logic r);
    for (int i = 0; i < DW; i++) remap[i] = r ? d[DW-1-i] : d[i];
  endfunction

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> sr[0] == $past(din) && sr[FW-1:1] == $past(sr[FW-2:0]));

  // R8
  hold_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> $stable(sr));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> codes == '0 && dout == 1'b0);

  // R5
  ignored_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld && (sr[FW-1:DW] == '0 || sr[FW-1:DW] > AW'(NCH)) |=> $stable(codes));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R4
    keep_other_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld && sr[FW-1:DW] == AW'(c + 1)) |=> $stable(codes[c*DW +: DW]));
    // R6
    write_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld && sr[FW-1:DW] == AW'(c + 1) |=>
        codes[c*DW +: DW] == remap($past(sr[DW-1:0]), $past(rev)));
  end
endmodule

bind sdac_front sdac_front_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .ld(ld), .rev(rev),
  .sr(sr), .dout(dout), .codes(codes)
);

// File: tb/sdac_front_bench.sv
module sdac_front_bench;
  localparam int PERIOD = 10;
  localparam int NCH = 10, DW = 10;

  logic clk = 0, rst_n = 0, din = 0, ld = 0, rev = 0;
  logic dout;
  logic [NCH*DW-1:0] codes;
  logic [DW-1:0] exp_q [NCH];
  int checks = 0, fails = 0;

  sdac_front u_sdac_front (.clk(clk), .rst_n(rst_n), .din(din), .ld(ld),
                           .rev(rev), .dout(dout), .codes(codes));

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [9:0] remap(input logic [9:0] d, input logic r);
    for (int i = 0; i < 10; i++) remap[i] = r ? d[9-i] : d[i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++) chk(req, 32'(codes[c*DW +: DW]), 32'(exp_q[c]));
  endtask

  task automatic send(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) begin
      din = f[i];
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic pulse_load(input logic [3:0] a, input logic [9:0] d, input logic r);
    rev = r; ld = 1;
    @(posedge clk); @(negedge clk);
    ld = 0;
    if (a >= 1 && a <= NCH) exp_q[a-1] = remap(d, r);
  endtask

  task automatic frame(input logic [3:0] a, input logic [9:0] d, input logic r, input string req);
    rev = ~r;
    send({a, d});
    pulse_load(a, d, r);
    check_all(req);
  endtask

  initial begin
    #(PERIOD*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) exp_q[c] = '0;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7", 32'(dout), 0);
    check_all("R7");
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R6 sweep over channels, orders and codes
    for (int r = 0; r < 2; r++)
      for (int ch = 1; ch <= NCH; ch++) begin
        for (int b = 0; b < DW; b++) frame(4'(ch), 10'(1 << b), r[0], "R4 R6");
        frame(4'(ch), 10'h3FF, r[0], "R4");
        frame(4'(ch), 10'(ch * 97 + r * 311), r[0], "R6");
        frame(4'(ch), 10'h000, r[0], "R4");
        frame(4'(ch), 10'(ch * 53 + 7), r[0], "R3");
      end

    // R5 unused channel numbers and test code
    frame(4'd0, 10'h155, 1'b0, "R5");
    for (int a = 11; a <= 15; a++) frame(4'(a), 10'h2AA, a[0], "R5");

    // R8 long load, serial line toggling
    frame(4'd3, 10'h0C5, 1'b0, "R8");
    rev = 1; ld = 1;
    for (int i = 0; i < 4; i++) begin
      din = ~din;
      @(posedge clk); @(negedge clk);
    end
    ld = 0;
    exp_q[2] = remap(10'h0C5, 1'b1);
    check_all("R8");
    pulse_load(4'd3, 10'h0C5, 1'b0);
    check_all("R8");

    // R1 R2 cascade: frame bits reappear 14 edges later
    send(14'b10_1101_0011_1001);
    for (int j = 0; j < 14; j++) begin
      chk("R2", 32'(dout), 32'(14'b10_1101_0011_1001 >> (13 - j)) & 1);
      din = j[0];
      @(posedge clk); @(negedge clk);
    end

    // R7 reset mid-run
    frame(4'd7, 10'h3A1, 1'b1, "R4");
    send(14'h3FFF);
    rst_n = 0;
    #1;
    for (int c = 0; c < NCH; c++) exp_q[c] = '0;
    check_all("R7");
    chk("R7", 32'(dout), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    frame(4'd10, 10'h201, 1'b0, "R4");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule